// File: doc/BRIEF.md
# Codec Link Reset Controller

This block sits on the codec end of a serial audio link and decides which of four kinds of reset is taking place: cold, warm, new warm or register-only. Each kind preserves a different amount of state. A free-running local oscillator clock samples three signals: the active-low reset pin, the SYNC line and a flag that says whether the bit clock is toggling. From them the block drives one gate that enables the bit clock and the serial data output, and a codec-ready flag. It also produces single-cycle strobes that clear the whole register file, the audio/vendor register group or the modem register group.

A reset-pin low pulse or a SYNC high pulse must last at least `MIN_CYC` oscillator cycles to count, so that glitches are filtered out. After a primary-mode warm wake, the gate stays closed for `RESTART_CYC` cycles after SYNC falls. In secondary mode, the wake is the bit clock starting again, and output resumes at the next frame start (a SYNC rise). The block snoops register writes and turns a write to index 00h or 3Ch into a reset of the matching register group, but only while the link is running. The low-power flag and the disable bit for the new warm reset come from the register file outside this block.

Top module: `link_reset_ctrl`

## Requirements
- R1: After power-on reset, `link_en_o` and `codec_rdy_o` are 0 until the synchronised reset pin reads high. Then `rst_all_o` pulses once, an event with kind 1 (cold) is reported, and `link_en_o` and `codec_rdy_o` go to 1.
- R2: A reset pin held low for at least `MIN_CYC` cycles, outside an enabled deep powerdown, is a cold reset. It forces `link_en_o` and `codec_rdy_o` to 0. On release it gives exactly one `rst_all_o` pulse and one event of kind 1, and it reopens the link.
- R3: A reset pin low pulse shorter than `MIN_CYC` cycles has no effect: the link stays enabled and no event is reported.
- R4: A rising edge of `lowpow_i` while the link runs halts the link: `link_en_o` and `codec_rdy_o` go to 0.
- R5: Primary mode (`secondary_i`=0), halted link, `bclk_act_i`=0: SYNC high for at least `MIN_CYC` cycles and then low reports an event of kind 2 (warm) with no `rst_all_o`. `link_en_o` rises no earlier than `RESTART_CYC` cycles after SYNC falls.
- R6: In primary mode, a SYNC high pulse shorter than `MIN_CYC` cycles is ignored. A SYNC high pulse of any length is also ignored while `bclk_act_i`=1. The link stays halted in both cases.
- R7: Secondary mode, halted link: a rise of `bclk_act_i` reports an event of kind 2. `link_en_o` stays 0 until the next SYNC rise and then goes to 1.
- R8: Halted link with `lowpow_i`=1 and `nwr_dis_i`=0: a reset pin low for at least `MIN_CYC` cycles and then high is a new warm reset. It reports an event of kind 3, gives no `rst_all_o` and reopens the link. With `nwr_dis_i`=1 the same stimulus is a cold reset (kind 1, with `rst_all_o`).
- R9: While the link runs, a write to index 00h gives a `rst_aud_o` pulse and an event of kind 4. A write to index 3Ch gives a `rst_mdm_o` pulse and an event of kind 5. Writes to other indices give no strobe.
- R10: Register writes while the link is halted or in reset give no strobe.
- R11: The three reset strobes are each one cycle wide and are never high together. `codec_rdy_o` stays 1 during a register-group strobe.
- R12: A cold reset overrides any warm wake in progress and any register write. It is reported as kind 1 with `rst_all_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin_n_i | input | 1 | Link reset pin, active low, asynchronous |
| sync_i | input | 1 | SYNC line, asynchronous |
| bclk_act_i | input | 1 | Bit clock toggling indication, asynchronous |
| secondary_i | input | 1 | 1 selects secondary codec behaviour |
| lowpow_i | input | 1 | Low-power (link halt) mode flag |
| nwr_dis_i | input | 1 | Disables the new warm reset |
| wr_vld_i | input | 1 | Register write command valid |
| wr_idx_i | input | IDX_W | Register write index |
| link_en_o | output | 1 | Gate for bit clock and serial data output |
| codec_rdy_o | output | 1 | Codec ready flag |
| rst_all_o | output | 1 | Full register reset strobe |
| rst_aud_o | output | 1 | Audio and vendor group reset strobe |
| rst_mdm_o | output | 1 | Modem group reset strobe |
| evt_vld_o | output | 1 | Reset event report valid |
| evt_kind_o | output | 3 | Event kind: 1 cold, 2 warm, 3 new warm, 4 audio group, 5 modem group |

## Verification
The bench builds the block with `MIN_CYC`=8 and `RESTART_CYC`=5, in place of the roughly 25 and 4 cycles a 24.576 MHz oscillator would need. With these values, pulses just under and just over the qualification length take only a few cycles. The restart gap can then be measured against a tight window, and every wake path in both primary and secondary mode fits into one short run. The index parameters keep their defaults, so the 00h and 3Ch decodes are tested as they would be used.

// File: rtl/lrc_pkg.sv
package lrc_pkg;

    typedef enum logic [2:0] {
        ST_COLD    = 3'd0,
        ST_RUN     = 3'd1,
        ST_OFF     = 3'd2,
        ST_RESTART = 3'd3,
        ST_WAITFRM = 3'd4
    } lrc_state_e;

    typedef enum logic [2:0] {
        EV_NONE    = 3'd0,
        EV_COLD    = 3'd1,
        EV_WARM    = 3'd2,
        EV_NWARM   = 3'd3,
        EV_REG_AUD = 3'd4,
        EV_REG_MDM = 3'd5
    } lrc_evt_e;

endpackage

// File: rtl/lrc_sync.sv
module lrc_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) stg_q[s] <= '0;
                else        stg_q[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) stg_q[s] <= '0;
                else        stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lrc_width.sv
module lrc_width #(
    parameter int MIN_CYC = 25
) (
    input  logic clk,
    input  logic por_n,
    input  logic lvl_i,
    output logic qual_o,
    output logic rose_o,
    output logic fell_o
);
    localparam int CW = $clog2(MIN_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          lvl;
    } wid_t;

    wid_t r_q, r_d;

    always_comb begin
        r_d     = r_q;
        r_d.lvl = lvl_i;
        if (!lvl_i)                       r_d.cnt = '0;
        else if (r_q.cnt != CW'(MIN_CYC)) r_d.cnt = r_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign qual_o = (r_q.cnt == CW'(MIN_CYC));
    assign rose_o = lvl_i & ~r_q.lvl;
    assign fell_o = ~lvl_i & r_q.lvl;

    AST_QUAL_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!por_n)
        qual_o |-> $past(lvl_i)) else $error("qualified without level");   // R3
    AST_FALL_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
        fell_o |=> !qual_o) else $error("qualification survived fall");    // R6
endmodule

// File: rtl/lrc_wrsnoop.sv
module lrc_wrsnoop #(
    parameter int              IDX_W   = 8,
    parameter logic [IDX_W-1:0] AUD_IDX = 8'h00,
    parameter logic [IDX_W-1:0] MDM_IDX = 8'h3C
) (
    input  logic             en_i,
    input  logic             wr_vld_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    output logic             hit_aud_o,
    output logic             hit_mdm_o
);
    always_comb begin
        hit_aud_o = en_i && wr_vld_i && (wr_idx_i == AUD_IDX);
        hit_mdm_o = en_i && wr_vld_i && (wr_idx_i == MDM_IDX) && !hit_aud_o;
    end
endmodule

// File: rtl/link_reset_ctrl.sv
module link_reset_ctrl
    import lrc_pkg::*;
#(
    parameter int               MIN_CYC     = 25,
    parameter int               RESTART_CYC = 4,
    parameter int               SYNC_STG    = 2,
    parameter int               IDX_W       = 8,
    parameter logic [IDX_W-1:0] AUD_IDX     = 8'h00,
    parameter logic [IDX_W-1:0] MDM_IDX     = 8'h3C
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_pin_n_i,
    input  logic             sync_i,
    input  logic             bclk_act_i,
    input  logic             secondary_i,
    input  logic             lowpow_i,
    input  logic             nwr_dis_i,
    input  logic             wr_vld_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    output logic             link_en_o,
    output logic             codec_rdy_o,
    output logic             rst_all_o,
    output logic             rst_aud_o,
    output logic             rst_mdm_o,
    output logic             evt_vld_o,
    output logic [2:0]       evt_kind_o
);
    localparam int RCW = $clog2(RESTART_CYC + 1);

    typedef struct packed {
        lrc_state_e     st;
        logic [RCW-1:0] rcnt;
        logic           link_en;
        logic           rdy;
        logic           rst_all;
        logic           rst_aud;
        logic           rst_mdm;
        logic           evt_vld;
        lrc_evt_e       evt;
        logic           lp;
        logic           bclk;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_COLD, rcnt: '0, link_en: 1'b0, rdy: 1'b0,
                                 rst_all: 1'b0, rst_aud: 1'b0, rst_mdm: 1'b0,
                                 evt_vld: 1'b0, evt: EV_NONE, lp: 1'b0, bclk: 1'b0};

    ctl_t r_q, r_d;

    // synchronised asynchronous inputs
    logic [2:0] raw_s;
    logic       pin_hi_s, sync_s, bclk_s;

    lrc_sync #(.WIDTH(3), .STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .d_i   ({rst_pin_n_i, sync_i, bclk_act_i}),
        .q_o   (raw_s)
    );
    assign {pin_hi_s, sync_s, bclk_s} = raw_s;

    // pulse-width qualification of reset-low and sync-high
    logic pin_low_qual, pin_low_rose, pin_low_fell;
    logic sync_qual, sync_rose, sync_fell;

    lrc_width #(.MIN_CYC(MIN_CYC)) u_pin_w (
        .clk    (clk),
        .por_n  (por_n),
        .lvl_i  (~pin_hi_s),
        .qual_o (pin_low_qual),
        .rose_o (pin_low_rose),
        .fell_o (pin_low_fell)
    );

    lrc_width #(.MIN_CYC(MIN_CYC)) u_sync_w (
        .clk    (clk),
        .por_n  (por_n),
        .lvl_i  (sync_s),
        .qual_o (sync_qual),
        .rose_o (sync_rose),
        .fell_o (sync_fell)
    );

    // register write snoop
    logic hit_aud, hit_mdm;

    lrc_wrsnoop #(.IDX_W(IDX_W), .AUD_IDX(AUD_IDX), .MDM_IDX(MDM_IDX)) u_snoop (
        .en_i      (r_q.st == ST_RUN),
        .wr_vld_i  (wr_vld_i),
        .wr_idx_i  (wr_idx_i),
        .hit_aud_o (hit_aud),
        .hit_mdm_o (hit_mdm)
    );

    logic nwr_armed, cold_go, bclk_rise, lp_rise;

    always_comb begin
        nwr_armed = (r_q.st == ST_OFF) && lowpow_i && !nwr_dis_i;
        cold_go   = pin_low_qual && !nwr_armed && (r_q.st != ST_COLD);
        bclk_rise = bclk_s && !r_q.bclk;
        lp_rise   = lowpow_i && !r_q.lp;
    end

    always_comb begin
        r_d         = r_q;
        r_d.rst_all = 1'b0;
        r_d.rst_aud = 1'b0;
        r_d.rst_mdm = 1'b0;
        r_d.evt_vld = 1'b0;
        r_d.evt     = EV_NONE;
        r_d.lp      = lowpow_i;
        r_d.bclk    = bclk_s;

        if (cold_go) begin
            r_d.st      = ST_COLD;
            r_d.link_en = 1'b0;
            r_d.rdy     = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_COLD: begin
                    if (pin_hi_s) begin
                        r_d.st      = ST_RUN;
                        r_d.link_en = 1'b1;
                        r_d.rdy     = 1'b1;
                        r_d.rst_all = 1'b1;
                        r_d.evt_vld = 1'b1;
                        r_d.evt     = EV_COLD;
                    end
                end
                ST_RUN: begin
                    if (lp_rise) begin
                        r_d.st      = ST_OFF;
                        r_d.link_en = 1'b0;
                        r_d.rdy     = 1'b0;
                    end else if (hit_aud) begin
                        r_d.rst_aud = 1'b1;
                        r_d.evt_vld = 1'b1;
                        r_d.evt     = EV_REG_AUD;
                    end else if (hit_mdm) begin
                        r_d.rst_mdm = 1'b1;
                        r_d.evt_vld = 1'b1;
                        r_d.evt     = EV_REG_MDM;
                    end
                end
                ST_OFF: begin
                    if (nwr_armed && pin_low_fell && pin_low_qual) begin
                        r_d.st      = ST_RUN;
                        r_d.link_en = 1'b1;
                        r_d.rdy     = 1'b1;
                        r_d.evt_vld = 1'b1;
                        r_d.evt     = EV_NWARM;
                    end else if (!secondary_i) begin
                        if (sync_fell && sync_qual && !bclk_s) begin
                            r_d.st      = ST_RESTART;
                            r_d.rcnt    = '0;
                            r_d.evt_vld = 1'b1;
                            r_d.evt     = EV_WARM;
                        end
                    end else if (bclk_rise) begin
                        r_d.st      = ST_WAITFRM;
                        r_d.evt_vld = 1'b1;
                        r_d.evt     = EV_WARM;
                    end
                end
                ST_RESTART: begin
                    if (r_q.rcnt == RCW'(RESTART_CYC - 1)) begin
                        r_d.st      = ST_RUN;
                        r_d.link_en = 1'b1;
                        r_d.rdy     = 1'b1;
                    end else begin
                        r_d.rcnt = r_q.rcnt + 1'b1;
                    end
                end
                ST_WAITFRM: begin
                    if (sync_rose) begin
                        r_d.st      = ST_RUN;
                        r_d.link_en = 1'b1;
                        r_d.rdy     = 1'b1;
                    end
                end
                default: begin
                    r_d.st      = ST_COLD;
                    r_d.link_en = 1'b0;
                    r_d.rdy     = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) r_q <= CTL_RST;
        else        r_q <= r_d;
    end

    assign link_en_o   = r_q.link_en;
    assign codec_rdy_o = r_q.rdy;
    assign rst_all_o   = r_q.rst_all;
    assign rst_aud_o   = r_q.rst_aud;
    assign rst_mdm_o   = r_q.rst_mdm;
    assign evt_vld_o   = r_q.evt_vld;
    assign evt_kind_o  = r_q.evt;

    AST_ALL_AFTER_OFF: assert property (@(posedge clk) disable iff (!por_n)
        rst_all_o |-> !$past(link_en_o)) else $error("full reset with link up");       // R2
    AST_WARM_HALTED: assert property (@(posedge clk) disable iff (!por_n)
        (evt_vld_o && evt_kind_o == EV_WARM) |-> !link_en_o) else $error("warm while up"); // R5
    AST_NWARM_KEEPS: assert property (@(posedge clk) disable iff (!por_n)
        (evt_vld_o && evt_kind_o == EV_NWARM) |-> !rst_all_o) else $error("new warm cleared"); // R8
    AST_REGRST_RUNNING: assert property (@(posedge clk) disable iff (!por_n)
        (rst_aud_o || rst_mdm_o) |-> $past(link_en_o)) else $error("group reset while off"); // R10
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0({rst_all_o, rst_aud_o, rst_mdm_o})) else $error("strobes overlap");     // R11
    AST_AUD_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
        rst_aud_o |=> !rst_aud_o) else $error("audio strobe wide");                        // R11
    AST_MDM_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
        rst_mdm_o |=> !rst_mdm_o) else $error("modem strobe wide");                        // R11
    AST_RDY_THRU_REGRST: assert property (@(posedge clk) disable iff (!por_n)
        (rst_aud_o || rst_mdm_o) |-> (codec_rdy_o && $past(codec_rdy_o))) else $error("ready dropped"); // R11
endmodule

// File: tb/link_reset_ctrl_test.sv
module link_reset_ctrl_test;
    localparam int MINC = 8;
    localparam int RSTC = 5;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       pin_n = 1'b0, sync = 1'b0, bclk = 1'b0, sec = 1'b0;
    logic       lowpow = 1'b0, nwr_dis = 1'b0, wr_vld = 1'b0;
    logic [7:0] wr_idx = 8'h00;
    logic       link_en, rdy, rst_all, rst_aud, rst_mdm, evt_vld;
    logic [2:0] evt_kind;

    int n_chk = 0, n_bad = 0;
    int n_ev [8];
    int n_all = 0, n_aud = 0, n_mdm = 0, n_wide = 0, n_rdy_bad = 0;
    logic p_all = 1'b0, p_aud = 1'b0, p_mdm = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    link_reset_ctrl #(.MIN_CYC(MINC), .RESTART_CYC(RSTC)) uut (
        .clk(clk), .por_n(por_n), .rst_pin_n_i(pin_n), .sync_i(sync),
        .bclk_act_i(bclk), .secondary_i(sec), .lowpow_i(lowpow), .nwr_dis_i(nwr_dis),
        .wr_vld_i(wr_vld), .wr_idx_i(wr_idx), .link_en_o(link_en), .codec_rdy_o(rdy),
        .rst_all_o(rst_all), .rst_aud_o(rst_aud), .rst_mdm_o(rst_mdm),
        .evt_vld_o(evt_vld), .evt_kind_o(evt_kind)
    );

    initial for (int i = 0; i < 8; i++) n_ev[i] = 0;

    always @(negedge clk) begin
        if (por_n) begin
            if (evt_vld) n_ev[evt_kind] = n_ev[evt_kind] + 1;
            if (rst_all) n_all = n_all + 1;
            if (rst_aud) n_aud = n_aud + 1;
            if (rst_mdm) n_mdm = n_mdm + 1;
            if ((rst_all && p_all) || (rst_aud && p_aud) || (rst_mdm && p_mdm)) n_wide = n_wide + 1;
            if ((rst_aud || rst_mdm) && !rdy) n_rdy_bad = n_rdy_bad + 1;
            p_all = rst_all; p_aud = rst_aud; p_mdm = rst_mdm;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic enter_off();
        lowpow = 1'b0; step(2);
        lowpow = 1'b1; step(4);
    endtask

    task automatic write_idx(input logic [7:0] idx);
        wr_vld = 1'b1; wr_idx = idx; step(1);
        wr_vld = 1'b0; step(4);
    endtask

    task automatic t_por();
        step(3);
        por_n = 1'b1;
        step(6);
        @(negedge clk);
        chk(link_en == 1'b0 && rdy == 1'b0, "R1 held while pin low", int'(link_en), 0);
        step(1);
        pin_n = 1'b1; step(8);
        @(negedge clk);
        chk(link_en == 1'b1 && rdy == 1'b1, "R1 link up after pin", int'(link_en), 1);
        chk(n_all == 1 && n_ev[1] == 1, "R1 one cold report", n_all, 1);
        step(1);
    endtask

    task automatic t_cold_short();
        int c0 = n_ev[1];
        pin_n = 1'b0; step(MINC - 3);
        pin_n = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk(link_en == 1'b1, "R3 short low keeps link", int'(link_en), 1);
        end
        chk(n_ev[1] == c0, "R3 no cold event", n_ev[1], c0);
        step(1);
    endtask

    task automatic t_cold_long();
        int c0 = n_ev[1], a0 = n_all;
        pin_n = 1'b0; step(MINC + 8);
        @(negedge clk);
        chk(link_en == 1'b0 && rdy == 1'b0, "R2 link closed in cold", int'(link_en), 0);
        step(1);
        pin_n = 1'b1; step(8);
        @(negedge clk);
        chk(link_en == 1'b1, "R2 link reopened", int'(link_en), 1);
        chk(n_ev[1] == c0 + 1 && n_all == a0 + 1, "R2 one full reset", n_all - a0, 1);
        step(1);
    endtask

    task automatic t_regs();
        int a0 = n_aud, m0 = n_mdm, e4 = n_ev[4], e5 = n_ev[5];
        write_idx(8'h00);
        chk(n_aud == a0 + 1 && n_mdm == m0, "R9 index 00h audio group", n_aud - a0, 1);
        chk(n_ev[4] == e4 + 1, "R9 kind 4 reported", n_ev[4] - e4, 1);
        write_idx(8'h3C);
        chk(n_mdm == m0 + 1 && n_aud == a0 + 1, "R9 index 3Ch modem group", n_mdm - m0, 1);
        chk(n_ev[5] == e5 + 1, "R9 kind 5 reported", n_ev[5] - e5, 1);
        write_idx(8'h02);
        write_idx(8'h5A);
        chk(n_aud == a0 + 1 && n_mdm == m0 + 1, "R9 other index no strobe", n_aud + n_mdm - a0 - m0, 2);
        chk(n_wide == 0 && n_rdy_bad == 0, "R11 single cycle, ready kept", n_wide + n_rdy_bad, 0);
        chk(link_en == 1'b1, "R11 link kept through group reset", int'(link_en), 1);
    endtask

    task automatic t_halt_and_warm();
        int a0, w0, c0, dly;
        enter_off();
        @(negedge clk);
        chk(link_en == 1'b0 && rdy == 1'b0, "R4 low power halts link", int'(link_en), 0);
        a0 = n_aud;
        write_idx(8'h00);
        chk(n_aud == a0, "R10 write while halted ignored", n_aud - a0, 0);
        w0 = n_ev[2];
        sync = 1'b1; step(MINC - 3); sync = 1'b0; step(20);
        chk(link_en == 1'b0 && n_ev[2] == w0, "R6 short sync ignored", int'(link_en), 0);
        bclk = 1'b1; step(2);
        sync = 1'b1; step(MINC + 3); sync = 1'b0; step(20);
        chk(link_en == 1'b0 && n_ev[2] == w0, "R6 sync with clock running ignored", int'(link_en), 0);
        bclk = 1'b0; step(3);
        a0 = n_all; c0 = n_ev[1];
        sync = 1'b1; step(MINC + 3);
        sync = 1'b0;
        dly = 0;
        while (!link_en && dly < 40) begin
            @(negedge clk);
            if (!link_en) dly++;
        end
        chk(dly >= RSTC + 1 && dly <= RSTC + 6, "R5 restart gap", dly, RSTC + 3);
        chk(n_ev[2] == w0 + 1 && n_all == a0, "R5 warm kept registers", n_ev[2] - w0, 1);
        step(1);
    endtask

    task automatic t_new_warm();
        int a0, n0, c0;
        enter_off();
        a0 = n_all; n0 = n_ev[3]; c0 = n_ev[1];
        pin_n = 1'b0; step(MINC + 6);
        @(negedge clk);
        chk(link_en == 1'b0 && n_ev[1] == c0, "R8 no cold in deep powerdown", n_ev[1] - c0, 0);
        step(1);
        pin_n = 1'b1; step(8);
        @(negedge clk);
        chk(link_en == 1'b1 && n_ev[3] == n0 + 1, "R8 new warm reopens", n_ev[3] - n0, 1);
        chk(n_all == a0, "R8 new warm keeps registers", n_all - a0, 0);
        step(1);
        enter_off();
        nwr_dis = 1'b1;
        a0 = n_all; n0 = n_ev[3]; c0 = n_ev[1];
        pin_n = 1'b0; step(MINC + 8);
        pin_n = 1'b1; step(8);
        @(negedge clk);
        chk(n_ev[1] == c0 + 1 && n_all == a0 + 1 && n_ev[3] == n0, "R8 disabled gives cold", n_ev[1] - c0, 1);
        step(1);
        nwr_dis = 1'b0;
    endtask

    task automatic t_secondary();
        int w0;
        enter_off();
        sec = 1'b1; w0 = n_ev[2];
        bclk = 1'b1; step(8);
        @(negedge clk);
        chk(n_ev[2] == w0 + 1 && link_en == 1'b0, "R7 clock resume is warm, gate shut", n_ev[2] - w0, 1);
        step(1);
        sync = 1'b1; step(2); sync = 1'b0; step(6);
        @(negedge clk);
        chk(link_en == 1'b1, "R7 output at frame start", int'(link_en), 1);
        step(1);
    endtask

    task automatic t_priority();
        int c0, a0, m0;
        lowpow = 1'b0; bclk = 1'b0; step(2);
        enter_off();
        bclk = 1'b1; step(8);
        c0 = n_ev[1]; a0 = n_all;
        pin_n = 1'b0; step(MINC + 8);
        m0 = n_aud;
        write_idx(8'h00);
        chk(n_aud == m0, "R12 write during cold ignored", n_aud - m0, 0);
        pin_n = 1'b1; step(8);
        @(negedge clk);
        chk(n_ev[1] == c0 + 1 && n_all == a0 + 1 && link_en == 1'b1, "R12 cold overrides pending wake",
            n_ev[1] - c0, 1);
        step(1);
        sec = 1'b0; bclk = 1'b0; lowpow = 1'b0;
    endtask

    initial begin
        t_por();
        t_cold_short();
        t_cold_long();
        t_regs();
        t_halt_and_warm();
        t_new_warm();
        t_secondary();
        t_priority();
        chk(n_wide == 0, "R11 no wide strobe overall", n_wide, 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad + 1);
            $finish;
        end
    end
endmodule